// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire stereo audio stream (bit clock, word select, serial data) into parallel left and right samples. All three wires are brought into a faster system clock domain through synchronizers. The block finds bit-clock rising edges there and samples data and word select on those edges. A 2-bit format code selects the framing. One code gives the delayed, MSB-first framing used by I2S. The other three give right-aligned framing, where the sample ends in the last bit slot before word select changes, with a word length of 16, 20 or 24 bits.

A finished stereo pair appears on two 24-bit outputs together with a strobe that lasts one system clock. The outputs keep their values until the next strobe. Format changes are applied only at the start of a left slot, so a frame is never decoded half in one format and half in another. The incomplete frame that follows reset produces no strobe.

Top module: `sar_rx`

## Requirements
- R1: While reset is asserted and right after it, `valid_o` is low and `left_o` and `right_o` are zero.
- R2: `fmt_i` is decoded as: 2'b00 I2S, 2'b01 right-aligned 16-bit, 2'b10 right-aligned 20-bit, 2'b11 right-aligned 24-bit.
- R3: In I2S framing, data and word select are sampled on bit-clock rising edges. Word select low marks the left channel. The MSB is in the slot one bit after the word-select change, and further bits follow MSB first.
- R4: In I2S framing, bits beyond the 24th in a channel slot are ignored, and a shorter word is padded with zeros at the LSB end.
- R5: In right-aligned framing, word select high marks the left channel. The LSB is in the last slot before word select changes. Bits that come before the configured word length in the slot are ignored.
- R6: In right-aligned framing, the 16-bit and 20-bit words are sign-extended to 24 bits.
- R7: `valid_o` is high for exactly one system clock after each right word completes. At that moment `left_o` and `right_o` carry the matching pair, and both hold their values until the next strobe.
- R8: A change on `fmt_i` takes effect at the start of the next left slot. The frame in flight is decoded entirely in the old format.
- R9: The first incomplete frame after reset is dropped: no strobe is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| ws_i | input | 1 | Word select (asynchronous) |
| sd_i | input | 1 | Serial data (asynchronous) |
| fmt_i | input | 2 | Framing format code |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench sends I2S words of 16, 20, 24 and 32 bits. If zero padding or truncation were wrong, the padded or cut-off words would come out shifted or carry stray low bits. Right-aligned frames carry negative values and non-zero filler ahead of the word. A receiver that did not sign-extend, or that shifted filler into the sample, would show wrong upper bits. The format code is switched in the middle of a left slot, with sample values that decode differently in the two formats, so applying the change immediately would corrupt the pair in flight. Any strobe during the dropped first frame after reset, or any strobe longer than one cycle, is reported.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ16 = 2'b01,
        FMT_RJ20 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    // word length of the right-aligned variants; I2S has none
    function automatic int rj_len(fmt_e f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            FMT_RJ24: return 24;
            default:  return 0;
        endcase
    endfunction

    // word-select level that marks the left channel
    function automatic logic left_level(fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    assign stg_d[0] = d_i;

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_chain
            assign stg_d[s] = stg_q[s-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
module sar_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/sar_slot_deser.sv
module sar_slot_deser
    import sar_pkg::*;
#(
    parameter int W        = 24,
    parameter int SLOT_MAX = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise_i,
    input  logic         ws_i,
    input  logic         sd_i,
    input  fmt_e         fmt_i,
    output logic         bnd_o,
    output logic         done_o,
    output logic         done_ws_o,
    output logic [W-1:0] word_o,
    output logic         started_o
);
    localparam int CW = $clog2(SLOT_MAX + 1);

    typedef struct packed {
        logic          primed;
        logic          started;
        logic          ws_last;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic [W-1:0]  shreg;
    } st_t;

    st_t q, d;
    logic sgn;
    int   len;

    always_comb begin
        d     = q;
        bnd_o = rise_i && q.primed && (ws_i != q.ws_last);
        if (rise_i) begin
            d.primed  = 1'b1;
            d.ws_last = ws_i;
            d.shreg   = {q.shreg[W-2:0], sd_i};
            if (bnd_o) begin
                d.started = 1'b1;
                d.cnt     = '0;
                d.acc     = '0;
            end else begin
                // MSB-first fill; slots past W bits leave acc untouched
                for (int i = 0; i < W; i++) begin
                    if (int'(q.cnt) == W - 1 - i) d.acc[i] = sd_i;
                end
                if (int'(q.cnt) < SLOT_MAX) d.cnt = q.cnt + CW'(1);
            end
        end
    end

    // word of the channel that the current boundary closes
    always_comb begin
        len = rj_len(fmt_i);
        sgn = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == len - 1) sgn = q.shreg[i];
        end
        if (fmt_i == FMT_I2S) begin
            word_o = q.acc;
        end else begin
            for (int i = 0; i < W; i++) word_o[i] = (i < len) ? q.shreg[i] : sgn;
        end
    end

    assign done_o    = bnd_o && q.started;
    assign done_ws_o = q.ws_last;
    assign started_o = q.started;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    p_started_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        q.started |=> q.started);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= CW'(SLOT_MAX));
endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_MAX    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bck_i,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic [1:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [2:0] pins_s;
    logic bck_s, ws_s, sd_s, rise;
    logic bnd, done, done_ws, started, ch_left;
    logic [SAMPLE_W-1:0] word;

    typedef struct packed {
        fmt_e                fmt;
        logic                have_left;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } top_t;

    top_t q, d;

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d_i ({bck_i, ws_i, sd_i}), .q_o (pins_s)
    );
    assign {bck_s, ws_s, sd_s} = pins_s;

    sar_edge u_edge (.clk (clk), .rst (rst), .lvl_i (bck_s), .rise_o (rise));

    sar_slot_deser #(.W(SAMPLE_W), .SLOT_MAX(SLOT_MAX)) u_deser (
        .clk (clk), .rst (rst), .rise_i (rise), .ws_i (ws_s), .sd_i (sd_s),
        .fmt_i (q.fmt), .bnd_o (bnd), .done_o (done), .done_ws_o (done_ws),
        .word_o (word), .started_o (started)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        ch_left = (done_ws == left_level(q.fmt));
        // format follows the pin until framing starts, then only at left start
        if (!started) begin
            d.fmt = fmt_e'(fmt_i);
        end else if (bnd && (ws_s == left_level(q.fmt))) begin
            d.fmt = fmt_e'(fmt_i);
        end
        if (done) begin
            if (ch_left) begin
                d.hold      = word;
                d.have_left = 1'b1;
            end else if (q.have_left) begin
                d.left      = q.hold;
                d.right     = word;
                d.valid     = 1'b1;
                d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign left_o  = q.left;
    assign right_o = q.right;
    assign valid_o = q.valid;

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    p_valid_after_edge_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(rise));

    p_fmt_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(started) && !$past(rise)) |-> $stable(q.fmt));
endmodule

// File: tb/sim_sar_rx.sv
module sim_sar_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BCK_HALF   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
    logic [1:0] fmt_i = 2'b00;
    logic [23:0] left_o, right_o;
    logic valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit width_chk = 0;
    logic [47:0] exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_rx u0 (
        .clk (clk), .rst (rst), .bck_i (bck_i), .ws_i (ws_i), .sd_i (sd_i),
        .fmt_i (fmt_i), .left_o (left_o), .right_o (right_o), .valid_o (valid_o)
    );

    task automatic push_exp(input logic [23:0] l, input logic [23:0] r, input string tag);
        exp_q.push_back({l, r});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            width_chk = 0;
        end else if (width_chk) begin
            checks++;
            if (valid_o) begin
                errors++;
                $display("FAIL R7 strobe width: valid=%b expected 0", valid_o);
            end
            width_chk = 0;
        end else if (valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected strobe: got %h/%h expected none", left_o, right_o);
            end else begin
                logic [47:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({left_o, right_o} !== e) begin
                    errors++;
                    $display("FAIL %s pair: got %h/%h expected %h/%h", t, left_o, right_o,
                             e[47:24], e[23:0]);
                end
            end
            width_chk = 1;
        end
    end

    task automatic drive_bit(input logic w, input logic b);
        bck_i = 1'b0; ws_i = w; sd_i = b;
        repeat (BCK_HALF) @(negedge clk);
        bck_i = 1'b1;
        repeat (BCK_HALF) @(negedge clk);
    endtask

    function automatic logic [23:0] i2s_exp(input logic [31:0] w, input int len);
        logic [31:0] t;
        if (len >= 24) t = w >> (len - 24);
        else           t = w << (24 - len);
        return t[23:0];
    endfunction

    function automatic logic [23:0] rj_exp(input logic [31:0] w, input int n);
        logic signed [31:0] t;
        t = $signed(w << (32 - n));
        t = t >>> (32 - n);
        return t[23:0];
    endfunction

    task automatic send_i2s(input logic [31:0] lw, input logic [31:0] rw, input int len,
                            input bit expect_it, input string tag);
        if (expect_it) push_exp(i2s_exp(lw, len), i2s_exp(rw, len), tag);
        for (int ch = 0; ch < 2; ch++) begin
            logic [31:0] w;
            logic wsv;
            w   = (ch == 0) ? lw : rw;
            wsv = (ch == 1);
            for (int k = 0; k < 32; k++) begin
                logic b;
                b = (k < len) ? w[len-1-k] : 1'b0;
                drive_bit((k == 31) ? ~wsv : wsv, b);
            end
        end
    endtask

    task automatic send_rj(input logic [31:0] lw, input logic [31:0] rw, input int n,
                           input bit expect_it, input string tag,
                           input int sw_k, input logic [1:0] sw_fmt);
        if (expect_it) push_exp(rj_exp(lw, n), rj_exp(rw, n), tag);
        for (int ch = 0; ch < 2; ch++) begin
            logic [31:0] w;
            logic wsv;
            w   = (ch == 0) ? lw : rw;
            wsv = (ch == 0);
            for (int k = 0; k < 32; k++) begin
                logic b;
                if (ch == 0 && k == sw_k) fmt_i = sw_fmt;
                b = (k >= 32 - n) ? w[31-k] : ((k % 3) == 0);
                drive_bit(wsv, b);
            end
        end
    endtask

    task automatic do_reset(input logic ws_idle);
        rst = 1'b1; bck_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
        repeat (5) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || left_o !== 24'h0 || right_o !== 24'h0) begin
            errors++;
            $display("FAIL R1 reset state: got v=%b %h/%h expected 0 0/0", valid_o, left_o, right_o);
        end
        rst = 1'b0;
        ws_i = ws_idle;
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || left_o !== 24'h0 || right_o !== 24'h0) begin
            errors++;
            $display("FAIL R1 after reset: got v=%b %h/%h expected 0 0/0", valid_o, left_o, right_o);
        end
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing strobes: got %0d pending expected 0", tag, exp_q.size());
        end
    endtask

    initial begin
        // I2S group (R2 code 00, R3, R4, R9 first frame dropped)
        fmt_i = 2'b00;
        do_reset(1'b0);
        send_i2s(32'h00AA5533, 32'h00123456, 24, 0, "R9");
        send_i2s(32'h00123456, 32'h00ABCDEF, 24, 1, "R3");
        send_i2s(32'h00800001, 32'h007FFFFE, 24, 1, "R3");
        send_i2s(32'h0000BEEF, 32'h00001234, 16, 1, "R4");
        send_i2s(32'hDEADBEEF, 32'h01234567, 32, 1, "R4");
        send_i2s(32'h000ABCDE, 32'h00012345, 20, 1, "R4");
        repeat (20) @(negedge clk);
        check_drained("R3");

        // right-aligned group (R2, R5, R6, R8, R9)
        fmt_i = 2'b01;
        do_reset(1'b1);
        send_rj(32'h00005A5A, 32'h0000A5A5, 16, 0, "R9", -1, 2'b01);
        send_rj(32'h00007FFF, 32'h00008000, 16, 1, "R6", -1, 2'b01);
        send_rj(32'h00001234, 32'h0000F00D, 16, 1, "R5", -1, 2'b01);
        fmt_i = 2'b10;
        send_rj(32'h00080000, 32'h0007FFFF, 20, 1, "R2", -1, 2'b10);
        fmt_i = 2'b11;
        send_rj(32'h00C0FFEE, 32'h0000BEEF, 24, 1, "R2", -1, 2'b11);
        send_rj(32'h00128001, 32'h003F7FFF, 24, 1, "R8", 10, 2'b01);
        send_rj(32'h00008001, 32'h00000042, 16, 1, "R8", -1, 2'b01);
        drive_bit(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check_drained("R5");

        checks++;
        if (left_o !== 24'hFF8001 || right_o !== 24'h000042) begin
            errors++;
            $display("FAIL R7 hold: got %h/%h expected ff8001/000042", left_o, right_o);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: got no completion expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule